// File: doc/BRIEF.md
# System Power Request Controller

This block is a small slave on a 32-bit register bus with a simple two-phase protocol: a setup phase, then an access phase. Software uses it to ask the surrounding platform logic for a system reset, an orderly shutdown, or a shutdown that is marked as a fatal error. The block only raises the request. The power sequencing, clock gating and the reset tree that act on it sit outside.

The block decodes a 256-byte window and implements two registers in it. The register at offset 0x00 is read-only and reports what the platform supports. The register at offset 0x04 is write-only and takes a command code. An accepted command becomes a one-cycle pulse on one of three request lines. A halt or panic command also sets a sticky flag, and while that flag is set the block accepts no further commands.

Any access that misses both registers is completed without a bus error, and the block flags it on a one-cycle strobe. The block has an interrupt output and an interrupt-enable state word, but no command sets either of them, so the line stays low.

Top module: `sysctl_top`

## Requirements
- R1: After the synchronous reset, reset_req, halt_req, panic_req, halted and unmapped_access are 0, and prdata is 0 whenever no read access phase is in progress.
- R2: A read access phase at offset 0x00 returns 0x00000001 on prdata in the same cycle; bit 0 = 1 means power control is supported.
- R3: A read access phase at any offset other than 0x00 returns 0x00000000, including offset 0x04.
- R4: A write access phase at offset 0x04 with data 1 drives reset_req high for exactly one clock cycle, starting in the cycle after the access phase, and leaves halted at 0.
- R5: A write of data 2 at offset 0x04 drives halt_req high for exactly one cycle, starting in the cycle after the access phase, and sets halted in that same cycle.
- R6: A write of data 3 at offset 0x04 drives panic_req high for exactly one cycle, starting in the cycle after the access phase, and sets halted in that same cycle.
- R7: A write at offset 0x04 of data 0, or of any 32-bit value above 3, raises no request line and does not change halted.
- R8: A write at any offset other than 0x04 raises no request line. A write at 0x00 does not change the value that later reads of 0x00 return.
- R9: Once halted is 1, it stays 1 until the reset input, and commands written while it is set raise no request line.
- R10: pready is always 1. Any read or write access phase at an offset other than 0x00 and 0x04 pulses unmapped_access for one cycle, starting in the cycle after the access phase.
- R11: irq stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the read access phase |
| pready | output | 1 | Transfer complete, always 1 |
| reset_req | output | 1 | One-cycle system reset request |
| halt_req | output | 1 | One-cycle orderly shutdown request |
| panic_req | output | 1 | One-cycle fatal-error shutdown request |
| halted | output | 1 | Sticky flag: a shutdown command was accepted |
| unmapped_access | output | 1 | One-cycle strobe after an access that missed both registers |
| irq | output | 1 | Interrupt line, always low |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, a 32-bit data path, the feature register at 0x00 and the command register at 0x04. With these values the whole 256-byte window and the full 32-bit command value can be reached from the bench. That includes offsets just beside a register (0x01, 0x05), the top of the window, and command values such as 4 and 0xFFFFFFFF that only a full-width compare rejects. The sticky halt flag is tested with the reset input between runs, so that the halt path and the panic path are each checked starting from the state after reset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int SYSCTL_ADDR_W = 8;
    localparam int SYSCTL_DATA_W = 32;
    localparam int SYSCTL_NUM_REQ = 3;

    localparam logic [SYSCTL_ADDR_W-1:0] OFS_CAPS = 8'h00;
    localparam logic [SYSCTL_ADDR_W-1:0] OFS_CMD  = 8'h04;

    localparam logic [SYSCTL_DATA_W-1:0] CAPS_WORD = 32'h0000_0001;

    // Command codes; request vector bit i corresponds to code i+1
    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_RESET = 2'd1,
        CMD_HALT  = 2'd2,
        CMD_PANIC = 2'd3
    } sysctl_cmd_e;

    // Decoded view of one bus cycle
    typedef struct packed {
        logic rd_caps;   // read access phase at capability offset
        logic wr_cmd;    // write access phase at command offset
        logic miss;      // access phase at neither register
    } sysctl_dec_t;

    // True when the full data word is one of the defined codes
    function automatic logic cmd_in_range(input logic [SYSCTL_DATA_W-1:0] word);
        return word <= SYSCTL_DATA_W'(CMD_PANIC);
    endfunction

    // True when the word selects a code that latches the halt flag
    function automatic logic cmd_stops(input logic [SYSCTL_DATA_W-1:0] word);
        return (word == SYSCTL_DATA_W'(CMD_HALT)) || (word == SYSCTL_DATA_W'(CMD_PANIC));
    endfunction

endpackage

// File: rtl/sysctl_bus_decode.sv
module sysctl_bus_decode
    import sysctl_pkg::*;
#(
    parameter int                ADDR_W   = SYSCTL_ADDR_W,
    parameter logic [ADDR_W-1:0] CAPS_OFS = OFS_CAPS,
    parameter logic [ADDR_W-1:0] CMD_OFS  = OFS_CMD
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output sysctl_dec_t       dec
);

    logic access;
    logic hit_caps;
    logic hit_cmd;

    always_comb begin
        access   = psel && penable;
        hit_caps = (paddr == CAPS_OFS);
        hit_cmd  = (paddr == CMD_OFS);

        dec.rd_caps = access && !pwrite && hit_caps;
        dec.wr_cmd  = access &&  pwrite && hit_cmd;
        dec.miss    = access && !(hit_caps || hit_cmd);
    end

endmodule

// File: rtl/sysctl_read_mux.sv
module sysctl_read_mux
    import sysctl_pkg::*;
#(
    parameter int                DATA_W = SYSCTL_DATA_W,
    parameter logic [DATA_W-1:0] CAPS   = CAPS_WORD
) (
    input  sysctl_dec_t       dec,
    output logic [DATA_W-1:0] rdata
);

    // Only the capability word is readable; everything else reads as zero
    always_comb begin
        rdata = '0;
        if (dec.rd_caps) begin
            rdata = CAPS;
        end
    end

endmodule

// File: rtl/sysctl_cmd_unit.sv
module sysctl_cmd_unit
    import sysctl_pkg::*;
#(
    parameter int DATA_W  = SYSCTL_DATA_W,
    parameter int NUM_REQ = SYSCTL_NUM_REQ
) (
    input  logic               clk,
    input  logic               rst,
    input  sysctl_dec_t        dec,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_REQ-1:0] req,
    output logic               halted,
    output logic               miss_strobe
);

    logic               accept;
    logic [NUM_REQ-1:0] req_q;
    logic               halted_q;
    logic               miss_q;

    // A command counts only when it is in range and the block is not halted
    assign accept = dec.wr_cmd && cmd_in_range(wdata) && !halted_q;

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[i] <= 1'b0;
            end else begin
                req_q[i] <= accept && (wdata == DATA_W'(i + 1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halted_q <= 1'b0;
            miss_q   <= 1'b0;
        end else begin
            miss_q <= dec.miss;
            if (accept && cmd_stops(wdata)) begin
                halted_q <= 1'b1;
            end
        end
    end

    assign req         = req_q;
    assign halted      = halted_q;
    assign miss_strobe = miss_q;

endmodule

// File: rtl/sysctl_top.sv
module sysctl_top
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = SYSCTL_ADDR_W,
    parameter int DATA_W = SYSCTL_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              reset_req,
    output logic              halt_req,
    output logic              panic_req,
    output logic              halted,
    output logic              unmapped_access,
    output logic              irq
);

    localparam int NREQ = SYSCTL_NUM_REQ;

    sysctl_dec_t       dec;
    logic [NREQ-1:0]   req_vec;
    logic [DATA_W-1:0] irq_en_q;
    logic              irq_src_q;

    sysctl_bus_decode #(
        .ADDR_W   (ADDR_W),
        .CAPS_OFS (ADDR_W'(OFS_CAPS)),
        .CMD_OFS  (ADDR_W'(OFS_CMD))
    ) u_decode (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .dec     (dec)
    );

    sysctl_read_mux #(
        .DATA_W (DATA_W),
        .CAPS   (DATA_W'(CAPS_WORD))
    ) u_rmux (
        .dec   (dec),
        .rdata (prdata)
    );

    sysctl_cmd_unit #(
        .DATA_W  (DATA_W),
        .NUM_REQ (NREQ)
    ) u_cmd (
        .clk         (clk),
        .rst         (rst),
        .dec         (dec),
        .wdata       (pwdata),
        .req         (req_vec),
        .halted      (halted),
        .miss_strobe (unmapped_access)
    );

    // Interrupt state exists but has no setting path
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en_q  <= '0;
            irq_src_q <= 1'b0;
        end else begin
            irq_en_q  <= irq_en_q;
            irq_src_q <= 1'b0;
        end
    end

    assign irq       = irq_src_q && (|irq_en_q);
    assign pready    = 1'b1;
    assign reset_req = req_vec[CMD_RESET - 1];
    assign halt_req  = req_vec[CMD_HALT - 1];
    assign panic_req = req_vec[CMD_PANIC - 1];

endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker (
    input logic        clk,
    input logic        rst,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [7:0]  paddr,
    input logic [31:0] pwdata,
    input logic [31:0] prdata,
    input logic        reset_req,
    input logic        halt_req,
    input logic        panic_req,
    input logic        halted,
    input logic        unmapped_access,
    input logic        irq
);

    logic acc;
    assign acc = psel && penable;

    AST_CAPS_READ: assert property (@(posedge clk) disable iff (rst)
        (acc && !pwrite && paddr == 8'h00) |-> (prdata == 32'h1)); // R2

    AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc && !pwrite && paddr != 8'h00) |-> (prdata == 32'h0)); // R3

    AST_RESET_CMD: assert property (@(posedge clk) disable iff (rst)
        (acc && pwrite && paddr == 8'h04 && pwdata == 32'd1 && !halted) |=> reset_req); // R4

    AST_HALT_CMD: assert property (@(posedge clk) disable iff (rst)
        (acc && pwrite && paddr == 8'h04 && pwdata == 32'd2 && !halted) |=> (halt_req && halted)); // R5

    AST_PANIC_CMD: assert property (@(posedge clk) disable iff (rst)
        (acc && pwrite && paddr == 8'h04 && pwdata == 32'd3 && !halted) |=> (panic_req && halted)); // R6

    AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (acc && pwrite && (pwdata == 32'd0 || pwdata > 32'd3)) |=> !(reset_req || halt_req || panic_req)); // R7

    AST_OTHER_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (acc && pwrite && paddr != 8'h04) |=> !(reset_req || halt_req || panic_req)); // R8

    AST_HALTED_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R9

    AST_HALTED_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        halted |=> !(reset_req || halt_req || panic_req)); // R9

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reset_req, halt_req, panic_req})); // R4

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (reset_req || halt_req || panic_req) |=> !(reset_req || halt_req || panic_req)); // R5

    AST_UNMAPPED_STROBE: assert property (@(posedge clk) disable iff (rst)
        (acc && paddr != 8'h00 && paddr != 8'h04) |=> unmapped_access); // R10

    AST_IRQ_LOW: assert property (@(posedge clk) disable iff (rst)
        !irq); // R11

endmodule

bind sysctl_top sysctl_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .psel            (psel),
    .penable         (penable),
    .pwrite          (pwrite),
    .paddr           (paddr),
    .pwdata          (pwdata),
    .prdata          (prdata),
    .reset_req       (reset_req),
    .halt_req        (halt_req),
    .panic_req       (panic_req),
    .halted          (halted),
    .unmapped_access (unmapped_access),
    .irq             (irq)
);

// File: tb/sysctl_top_tb.sv
module sysctl_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        reset_req, halt_req, panic_req, halted, unmapped_access, irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd_seen;

    always #4 clk = ~clk;

    sysctl_top u_dut (
        .clk (clk), .rst (rst), .psel (psel), .penable (penable),
        .pwrite (pwrite), .paddr (paddr), .pwdata (pwdata),
        .prdata (prdata), .pready (pready),
        .reset_req (reset_req), .halt_req (halt_req), .panic_req (panic_req),
        .halted (halted), .unmapped_access (unmapped_access), .irq (irq)
    );

    // req field: bit0 reset, bit1 halt, bit2 panic
    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic [2:0]  exp_req;
        logic        exp_unm;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 32'h0,        32'h1, 3'b000, 1'b0, 8'd2},  // R2
        '{1'b0, 8'h04, 32'h0,        32'h0, 3'b000, 1'b0, 8'd3},  // R3
        '{1'b0, 8'h08, 32'h0,        32'h0, 3'b000, 1'b1, 8'd10}, // R10
        '{1'b0, 8'hFC, 32'h0,        32'h0, 3'b000, 1'b1, 8'd3},  // R3
        '{1'b1, 8'h04, 32'h1,        32'h0, 3'b001, 1'b0, 8'd4},  // R4
        '{1'b1, 8'h04, 32'h0,        32'h0, 3'b000, 1'b0, 8'd7},  // R7
        '{1'b1, 8'h04, 32'h4,        32'h0, 3'b000, 1'b0, 8'd7},  // R7
        '{1'b1, 8'h04, 32'hFFFFFFFF, 32'h0, 3'b000, 1'b0, 8'd7},  // R7
        '{1'b1, 8'h00, 32'h2,        32'h0, 3'b000, 1'b0, 8'd8},  // R8
        '{1'b1, 8'h10, 32'h2,        32'h0, 3'b000, 1'b1, 8'd8},  // R8
        '{1'b0, 8'h00, 32'h0,        32'h1, 3'b000, 1'b0, 8'd8},  // R8
        '{1'b1, 8'h04, 32'h1,        32'h0, 3'b001, 1'b0, 8'd4},  // R4
        '{1'b1, 8'h05, 32'h3,        32'h0, 3'b000, 1'b1, 8'd10}, // R10
        '{1'b0, 8'h01, 32'h0,        32'h1 ^ 32'h1, 3'b000, 1'b1, 8'd3} // R3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Two-phase transfer; prdata captured in the access phase, before the edge
    task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1 rd_seen = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    function automatic logic [31:0] reqs();
        return {29'b0, panic_req, halt_req, reset_req};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 reqs", reqs(), 32'h0);
        chk("R1 halted", {31'b0, halted}, 32'h0);
        chk("R1 unmapped", {31'b0, unmapped_access}, 32'h0);
        chk("R1 idle prdata", prdata, 32'h0);
        chk("R11 irq", {31'b0, irq}, 32'h0);
        chk("R10 pready", {31'b0, pready}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("R%0d vec%0d", VECS[i].tag, i);
            xfer(VECS[i].wr, VECS[i].addr, VECS[i].data);
            if (!VECS[i].wr) chk({t, " prdata"}, rd_seen, VECS[i].exp_rd);
            chk({t, " req"}, reqs(), {29'b0, VECS[i].exp_req});
            chk({t, " unmapped"}, {31'b0, unmapped_access}, {31'b0, VECS[i].exp_unm});
            chk({t, " halted"}, {31'b0, halted}, 32'h0);
            @(negedge clk);
            chk({t, " pulse end"}, reqs(), 32'h0);
            chk({t, " strobe end"}, {31'b0, unmapped_access}, 32'h0);
        end

        // R5 halt command, then sticky behaviour R9
        xfer(1'b1, 8'h04, 32'd2);
        chk("R5 halt_req", reqs(), 32'h2);
        chk("R5 halted set", {31'b0, halted}, 32'h1);
        @(negedge clk);
        chk("R5 single pulse", reqs(), 32'h0);
        xfer(1'b1, 8'h04, 32'd1);
        chk("R9 reset blocked", reqs(), 32'h0);
        xfer(1'b1, 8'h04, 32'd3);
        chk("R9 panic blocked", reqs(), 32'h0);
        chk("R9 still halted", {31'b0, halted}, 32'h1);
        chk("R11 irq halted", {31'b0, irq}, 32'h0);
        do_reset();
        @(negedge clk);
        chk("R9 cleared by reset", {31'b0, halted}, 32'h0);

        // R6 panic command
        xfer(1'b1, 8'h04, 32'd3);
        chk("R6 panic_req", reqs(), 32'h4);
        chk("R6 halted set", {31'b0, halted}, 32'h1);
        @(negedge clk);
        chk("R6 single pulse", reqs(), 32'h0);
        xfer(1'b0, 8'h00, 32'h0);
        chk("R2 read while halted", rd_seen, 32'h1);
        do_reset();
        @(negedge clk);
        // R4 after reset works again, halted stays clear
        xfer(1'b1, 8'h04, 32'd1);
        chk("R4 reset_req after reset", reqs(), 32'h1);
        chk("R4 no halt flag", {31'b0, halted}, 32'h0);
        chk("R10 pready end", {31'b0, pready}, 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule